// File: doc/BRIEF.md
# Eight-by-eight audio input mixer matrix

The block forms eight mixed audio outputs from eight input channels. Each output is a weighted sum of all eight inputs, and each output has its own eight signed gains. A frame strobe delivers one 24-bit sample per input. The block then computes one output row per clock using eight parallel multipliers. Each row's sum is rounded, scaled back by 2^23 and clipped to the 24-bit range. A one-cycle valid pulse marks the frame's results.

Gains are loaded through a byte-wide control port. A subaddress strobe selects a mixer and restarts a burst. Then up to 32 data bytes carry that mixer's eight gains as 32-bit words, most significant byte first. A gain is assembled in a holding register and committed to a staging bank only when its fourth byte arrives. The whole staging bank is copied into the bank used for arithmetic when a frame is accepted. This means the arithmetic never sees a torn gain, and a change made during a frame takes effect from the next frame.

If a subaddress strobe and a data strobe occur in the same cycle, the subaddress strobe wins and the data byte is dropped.

Top module: `mixmat_matrix`

## Requirements
- R1: After reset, `mix_vld` is low and every output lane is 0. The gain bank holds identity routing, so output n equals input n.
- R2: Output m is computed as follows. Take S = sum over i of x_i * g_mi, then form (S + 2^22) >>> 23 (round half up). For example, a gain of 0.5 on input 3 gives 2, and on input -3 gives -1.
- R3: Each output is clipped to the range -8388608 to 8388607.
- R4: Subaddresses 0x41 through 0x48 select mixers 0 through 7. Mixer m drives `mix_out[24m+23:24m]`, and input i is `frame_smp[24i+23:24i]`.
- R5: A burst carries eight 4-byte words, most significant byte first. Word k of the burst is the gain applied to input k. Bits 27:0 of a word are a two's-complement gain with 23 fraction bits, so 0x0800000 is unity. Bits 31:28 are ignored.
- R6: A gain changes only when the fourth byte of its word arrives. A new subaddress strobe restarts the byte count and discards any partly sent word.
- R7: Data bytes beyond the 32nd of a burst change no gain.
- R8: After a subaddress outside 0x41 to 0x48, data bytes change no gain.
- R9: A frame strobe accepted at clock edge 0 raises `mix_vld` for exactly one cycle after edge 8. All outputs then hold until the next accepted frame starts updating them.
- R10: Gain words completed after a frame has been accepted apply from the next accepted frame. A frame strobe that arrives while a frame is being computed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | Frame strobe; samples are taken when it is accepted |
| frame_smp | input | 192 | Eight signed 24-bit input samples, input i at bits 24i+23:24i |
| ctl_addr_stb | input | 1 | Subaddress strobe; starts a new burst |
| ctl_addr | input | 8 | Subaddress |
| ctl_data_stb | input | 1 | Data byte strobe |
| ctl_data | input | 8 | Data byte |
| mix_out | output | 192 | Eight signed 24-bit mixed outputs, mixer m at bits 24m+23:24m |
| mix_vld | output | 1 | One-cycle pulse when all eight outputs of a frame are ready |

## Verification
The results of a frame are due in the cycle after the ninth rising edge counted from the edge that accepts the strobe. The bench drives inputs and samples outputs on falling edges, counts eight falling edges after the strobe is released, and then requires `mix_vld` high exactly there and low both before and one cycle after. A gain word takes one clock per byte. Its effect is observed only through the next frame, whose expected values come from a bench copy of the staging bank taken when that frame's strobe is driven. Concurrent writes during a running frame are therefore checked against the bank as it stood at the strobe.

// File: rtl/mixmat_pkg.sv
package mixmat_pkg;

    // Default geometry of the mixer matrix
    localparam int MIX_NCH      = 8;     // inputs and outputs
    localparam int MIX_SW       = 24;    // sample width
    localparam int MIX_CW       = 28;    // gain width
    localparam int MIX_FRAC     = 23;    // gain fraction bits
    localparam int MIX_BASE_SUB = 'h41;  // subaddress of mixer 0

endpackage

// File: rtl/mixmat_coef_bank.sv
module mixmat_coef_bank
    import mixmat_pkg::*;
#(
    parameter int NCH      = MIX_NCH,
    parameter int CW       = MIX_CW,
    parameter int FRAC     = MIX_FRAC,
    parameter int BASE_SUB = MIX_BASE_SUB
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               addr_stb,
    input  logic [7:0]                         addr,
    input  logic                               data_stb,
    input  logic [7:0]                         data,
    input  logic                               apply,
    output logic [NCH-1:0][NCH-1:0][CW-1:0]    act_gain
);

    localparam int WB    = 4;                 // bytes per gain word
    localparam int BURST = NCH * WB;          // bytes per mixer
    localparam int CNTW  = $clog2(BURST + 1);
    localparam int SELW  = $clog2(NCH);
    localparam int HW    = CW - 8;            // bits kept from the first three bytes

    typedef logic [NCH-1:0][NCH-1:0][CW-1:0] gains_t;

    typedef struct packed {
        logic             ok;
        logic [SELW-1:0]  sel;
        logic [CNTW-1:0]  cnt;
        logic [HW-1:0]    hold;
        gains_t           stage;
        gains_t           act;
    } bank_t;

    function automatic gains_t identity_gains();
        gains_t g;
        for (int m = 0; m < NCH; m++) begin
            for (int i = 0; i < NCH; i++) begin
                g[m][i] = (m == i) ? (CW'(1) << FRAC) : '0;
            end
        end
        return g;
    endfunction

    localparam bank_t BANK_RST = '{
        ok:    1'b0,
        sel:   '0,
        cnt:   '0,
        hold:  '0,
        stage: identity_gains(),
        act:   identity_gains()
    };

    bank_t bank_d, bank_q;
    logic  addr_in_range;

    assign addr_in_range = ({1'b0, addr} >= 9'(BASE_SUB)) &&
                           ({1'b0, addr} <  9'(BASE_SUB + NCH));

    always_comb begin
        bank_d = bank_q;
        if (addr_stb) begin
            bank_d.ok  = addr_in_range;
            bank_d.sel = SELW'(addr - 8'(BASE_SUB));
            bank_d.cnt = '0;
        end else if (data_stb && bank_q.ok && (bank_q.cnt < CNTW'(BURST))) begin
            if (bank_q.cnt[1:0] == 2'd3) begin
                bank_d.stage[bank_q.sel][bank_q.cnt[2 +: SELW]] = {bank_q.hold, data};
            end else begin
                bank_d.hold = {bank_q.hold[HW-9:0], data};
            end
            bank_d.cnt = bank_q.cnt + CNTW'(1);
        end
        if (apply) begin
            bank_d.act = bank_q.stage;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= BANK_RST;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign act_gain = bank_q.act;

    AST_ACT_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(bank_q.act)); // R10
    AST_BURST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q.cnt <= CNTW'(BURST)); // R7
    AST_BAD_SUB_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && !addr_stb && !bank_q.ok) |=> $stable(bank_q.stage)); // R8
    AST_PARTIAL_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && !addr_stb && (bank_q.cnt[1:0] != 2'd3)) |=> $stable(bank_q.stage)); // R6

endmodule

// File: rtl/mixmat_mac_lane.sv
module mixmat_mac_lane
    import mixmat_pkg::*;
#(
    parameter int NCH  = MIX_NCH,
    parameter int SW   = MIX_SW,
    parameter int CW   = MIX_CW,
    parameter int FRAC = MIX_FRAC
) (
    input  logic [NCH-1:0][SW-1:0] smp,
    input  logic [NCH-1:0][CW-1:0] gain,
    output logic [SW-1:0]          y
);

    localparam int PW = SW + CW;
    localparam int AW = PW + $clog2(NCH) + 1;

    localparam logic signed [AW-1:0] HALF = AW'(1) << (FRAC - 1);
    localparam logic signed [AW-1:0] VMAX = AW'((64'(1) << (SW - 1)) - 1);
    localparam logic signed [AW-1:0] VMIN = -(AW'(1) << (SW - 1));

    logic signed [PW-1:0] prod [NCH];
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] scaled;

    for (genvar g = 0; g < NCH; g++) begin : g_mul
        assign prod[g] = $signed(smp[g]) * $signed(gain[g]);
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NCH; i++) begin
            acc = acc + AW'(prod[i]);
        end
        scaled = (acc + HALF) >>> FRAC;
        if (scaled > VMAX) begin
            y = VMAX[SW-1:0];
        end else if (scaled < VMIN) begin
            y = VMIN[SW-1:0];
        end else begin
            y = scaled[SW-1:0];
        end
    end

endmodule

// File: rtl/mixmat_seq.sv
module mixmat_seq
    import mixmat_pkg::*;
#(
    parameter int NCH = MIX_NCH,
    parameter int SW  = MIX_SW
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_stb,
    input  logic [NCH-1:0][SW-1:0]        frame_smp,
    input  logic [SW-1:0]                 lane_y,
    output logic                          apply,
    output logic [$clog2(NCH)-1:0]        row,
    output logic [NCH-1:0][SW-1:0]        smp_held,
    output logic [NCH-1:0][SW-1:0]        outs,
    output logic                          vld
);

    localparam int              SELW = $clog2(NCH);
    localparam logic [SELW-1:0] LAST = SELW'(NCH - 1);

    typedef struct packed {
        logic                   busy;
        logic [SELW-1:0]        row;
        logic [NCH-1:0][SW-1:0] smp;
        logic [NCH-1:0][SW-1:0] outs;
        logic                   vld;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.vld = 1'b0;
        apply     = 1'b0;
        if (!seq_q.busy) begin
            if (frame_stb) begin
                seq_d.busy = 1'b1;
                seq_d.row  = '0;
                seq_d.smp  = frame_smp;
                apply      = 1'b1;
            end
        end else begin
            seq_d.outs[seq_q.row] = lane_y;
            if (seq_q.row == LAST) begin
                seq_d.busy = 1'b0;
                seq_d.vld  = 1'b1;
            end else begin
                seq_d.row = seq_q.row + SELW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign row      = seq_q.row;
    assign smp_held = seq_q.smp;
    assign outs     = seq_q.outs;
    assign vld      = seq_q.vld;

    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.vld |=> !seq_q.vld); // R9
    AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !seq_q.busy) |=> (seq_q.busy && seq_q.row == '0)); // R9
    AST_LAST_ROW_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.row == LAST) |=> (seq_q.vld && !seq_q.busy)); // R9
    AST_OUT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.busy |=> $stable(seq_q.outs)); // R9
    AST_BUSY_STB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && frame_stb) |=> $stable(seq_q.smp)); // R10

endmodule

// File: rtl/mixmat_matrix.sv
module mixmat_matrix
    import mixmat_pkg::*;
#(
    parameter int NCH      = MIX_NCH,
    parameter int SW       = MIX_SW,
    parameter int CW       = MIX_CW,
    parameter int FRAC     = MIX_FRAC,
    parameter int BASE_SUB = MIX_BASE_SUB
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_stb,
    input  logic [NCH*SW-1:0]   frame_smp,
    input  logic                ctl_addr_stb,
    input  logic [7:0]          ctl_addr,
    input  logic                ctl_data_stb,
    input  logic [7:0]          ctl_data,
    output logic [NCH*SW-1:0]   mix_out,
    output logic                mix_vld
);

    localparam int SELW = $clog2(NCH);

    logic [NCH-1:0][SW-1:0]         smp_in;
    logic [NCH-1:0][SW-1:0]         smp_held;
    logic [NCH-1:0][SW-1:0]         outs;
    logic [NCH-1:0][NCH-1:0][CW-1:0] act_gain;
    logic [SELW-1:0]                row;
    logic                           apply;
    logic [SW-1:0]                  lane_y;

    assign smp_in  = frame_smp;
    assign mix_out = outs;

    mixmat_coef_bank #(
        .NCH      (NCH),
        .CW       (CW),
        .FRAC     (FRAC),
        .BASE_SUB (BASE_SUB)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_stb (ctl_addr_stb),
        .addr     (ctl_addr),
        .data_stb (ctl_data_stb),
        .data     (ctl_data),
        .apply    (apply),
        .act_gain (act_gain)
    );

    mixmat_mac_lane #(
        .NCH  (NCH),
        .SW   (SW),
        .CW   (CW),
        .FRAC (FRAC)
    ) u_lane (
        .smp  (smp_held),
        .gain (act_gain[row]),
        .y    (lane_y)
    );

    mixmat_seq #(
        .NCH (NCH),
        .SW  (SW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .frame_smp (smp_in),
        .lane_y    (lane_y),
        .apply     (apply),
        .row       (row),
        .smp_held  (smp_held),
        .outs      (outs),
        .vld       (mix_vld)
    );

endmodule

// File: tb/sim_mixmat_matrix.sv
module sim_mixmat_matrix;

    localparam int NCH = 8;
    localparam int SW  = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_stb = 1'b0;
    logic [NCH*SW-1:0] frame_smp = '0;
    logic              ctl_addr_stb = 1'b0;
    logic [7:0]        ctl_addr = '0;
    logic              ctl_data_stb = 1'b0;
    logic [7:0]        ctl_data = '0;
    logic [NCH*SW-1:0] mix_out;
    logic              mix_vld;

    always #5 clk = ~clk;

    mixmat_matrix u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_stb    (frame_stb),
        .frame_smp    (frame_smp),
        .ctl_addr_stb (ctl_addr_stb),
        .ctl_addr     (ctl_addr),
        .ctl_data_stb (ctl_data_stb),
        .ctl_data     (ctl_data),
        .mix_out      (mix_out),
        .mix_vld      (mix_vld)
    );

    int          checks = 0;
    int          bad = 0;
    longint      stage_m [NCH][NCH];
    longint      act_m   [NCH][NCH];
    longint      xs      [NCH];
    logic [31:0] wv      [NCH];
    int          m_ok = 0;
    int          m_sel = 0;
    int          m_cnt = 0;
    logic [31:0] m_hold = '0;
    int          dup_at = 0;

    task automatic chk(input string req, input longint actual, input longint expected);
        checks++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic longint sx28(input logic [31:0] w);
        return longint'({{36{w[27]}}, w[27:0]});
    endfunction

    function automatic longint sx24(input logic [31:0] w);
        return longint'({{40{w[23]}}, w[23:0]});
    endfunction

    function automatic longint lane(input int m);
        return sx24({8'h0, mix_out[SW*m +: SW]});
    endfunction

    function automatic longint expect_out(input int m, input longint x [NCH]);
        longint s = 0;
        longint r;
        for (int i = 0; i < NCH; i++) s += act_m[m][i] * x[i];
        r = (s + (64'sd1 <<< 22)) >>> 23;
        if (r > 8388607) r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    task automatic put_addr(input logic [7:0] a);
        ctl_addr_stb = 1'b1;
        ctl_addr = a;
        m_cnt = 0;
        m_ok = (a >= 8'h41 && a <= 8'h48) ? 1 : 0;
        m_sel = int'(a) - 'h41;
        @(negedge clk);
        ctl_addr_stb = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        ctl_data_stb = 1'b1;
        ctl_data = b;
        if (m_ok != 0 && m_cnt < 32) begin
            m_hold = {m_hold[23:0], b};
            if (m_cnt % 4 == 3) stage_m[m_sel][m_cnt / 4] = sx28(m_hold);
            m_cnt++;
        end
        @(negedge clk);
        ctl_data_stb = 1'b0;
    endtask

    task automatic write_mix(input logic [7:0] a);
        put_addr(a);
        for (int k = 0; k < NCH; k++)
            for (int b = 3; b >= 0; b--) put_byte(wv[k][8*b +: 8]);
    endtask

    task automatic run_frame(input string req);
        longint xe [NCH];
        int     vld_ok = 1;
        for (int i = 0; i < NCH; i++) begin
            frame_smp[SW*i +: SW] = xs[i][SW-1:0];
            xe[i] = xs[i];
            for (int k = 0; k < NCH; k++) act_m[i][k] = stage_m[i][k];
        end
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        for (int j = 2; j <= 9; j++) begin
            @(negedge clk);
            if (dup_at == j) begin
                frame_stb = 1'b1;
                frame_smp = ~frame_smp;
            end else begin
                frame_stb = 1'b0;
            end
            if (mix_vld != (j == 9)) vld_ok = 0;
        end
        chk("R9 valid due 9 edges after strobe", vld_ok, 1);
        for (int m = 0; m < NCH; m++) chk(req, lane(m), expect_out(m, xe));
        @(negedge clk);
        chk("R9 valid lasts one cycle", mix_vld, 0);
        for (int m = 0; m < NCH; m++) chk("R9 outputs held", lane(m), expect_out(m, xe));
    endtask

    task automatic rand_samples();
        for (int i = 0; i < NCH; i++) xs[i] = sx24($urandom);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int m = 0; m < NCH; m++)
            for (int i = 0; i < NCH; i++) stage_m[m][i] = (m == i) ? 64'sh800000 : 0;

        repeat (4) @(negedge clk);
        chk("R1 reset valid", mix_vld, 0);
        chk("R1 reset outputs", longint'(mix_out != '0), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: identity routing from reset, including both extremes
        rand_samples();
        xs[0] = 8388607;
        xs[5] = -8388608;
        run_frame("R1 identity");

        // R2: rounding half up with a 0.5 gain
        for (int k = 0; k < NCH; k++) wv[k] = 32'h0;
        wv[0] = 32'h0040_0000;
        write_mix(8'h41);
        for (int i = 0; i < NCH; i++) xs[i] = 0;
        xs[0] = 3;
        run_frame("R2");
        chk("R2 round of 1.5", lane(0), 2);
        xs[0] = -3;
        run_frame("R2");
        chk("R2 round of -1.5", lane(0), -1);

        // R4: every subaddress/input position, gain 0.5 with junk upper nibble
        for (int m = 0; m < NCH; m++) begin
            for (int i = 0; i < NCH; i++) begin
                for (int k = 0; k < NCH; k++) wv[k] = 32'h0;
                wv[i] = 32'hF040_0000;
                write_mix(8'(8'h41 + m));
                rand_samples();
                run_frame("R4 mapping");
            end
        end

        // R5: random full words, upper nibble random
        for (int r = 0; r < 3; r++) begin
            for (int m = 0; m < NCH; m++) begin
                for (int k = 0; k < NCH; k++) wv[k] = $urandom & 32'hF0FF_FFFF;
                write_mix(8'(8'h41 + m));
            end
            rand_samples();
            run_frame("R5 word format");
        end

        // R3: positive and negative clipping
        for (int k = 0; k < NCH; k++) wv[k] = 32'h07FF_FFFF;
        write_mix(8'h41);
        for (int k = 0; k < NCH; k++) wv[k] = 32'h0800_0000;
        write_mix(8'h42);
        for (int i = 0; i < NCH; i++) xs[i] = 8388607;
        run_frame("R3");
        chk("R3 clip high", lane(0), 8388607);
        chk("R3 clip low", lane(1), -8388608);

        // R6: partial word, then restart of the burst
        for (int k = 0; k < NCH; k++) wv[k] = (k == 2) ? 32'h0080_0000 : 32'h0;
        write_mix(8'h43);
        put_addr(8'h43);
        put_byte(8'h00);
        put_byte(8'h7F);
        put_byte(8'hFF);
        rand_samples();
        run_frame("R6 partial unused");
        put_byte(8'hFF);
        rand_samples();
        run_frame("R6 completed word");
        put_addr(8'h43);
        put_byte(8'h00);
        put_byte(8'h33);
        put_addr(8'h43);
        put_byte(8'h00);
        put_byte(8'h10);
        put_byte(8'h00);
        put_byte(8'h00);
        rand_samples();
        run_frame("R6 restart");
        chk("R6 restart gain", lane(2), expect_out(2, xs));

        // R7: bytes past the 32nd
        for (int k = 0; k < NCH; k++) wv[k] = 32'h0020_0000;
        write_mix(8'h45);
        put_byte(8'h00);
        put_byte(8'h80);
        put_byte(8'h00);
        put_byte(8'h00);
        rand_samples();
        run_frame("R7 overrun");

        // R8: subaddresses outside the mixer range
        put_addr(8'h40);
        for (int b = 0; b < 32; b++) put_byte(8'h11);
        put_addr(8'h49);
        for (int b = 0; b < 32; b++) put_byte(8'h22);
        put_addr(8'h00);
        for (int b = 0; b < 4; b++) put_byte(8'h44);
        rand_samples();
        run_frame("R8 bad subaddress");

        // R10: write during a running frame, plus a strobe while busy
        rand_samples();
        dup_at = 4;
        fork
            run_frame("R10 old gains in frame");
            begin
                @(negedge clk);
                @(negedge clk);
                put_addr(8'h46);
                put_byte(8'h00);
                put_byte(8'h40);
                put_byte(8'h00);
                put_byte(8'h00);
            end
        join
        dup_at = 0;
        rand_samples();
        run_frame("R10 new gains next frame");

        finish_run();
    end

endmodule